// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a large set of interrupt request lines into one request to the processor. Each source has its own programmable priority. A small group of low-numbered sources are flags that software raises and lowers through the register port. Every hardware source is qualified by its own enable and mask inputs. One hardware source number also takes the OR of a bundle of sub-requests. The controller compares the best pending source against a current-priority level. It raises the processor request when that source is strictly above the level, and it presents the source's vector while the request is up.

A two-state machine governs the request. In `ST_IDLE` the request is low. The transition *raise* (a qualifying source exists) moves to `ST_HELD` and commits that source. While in `ST_HELD` the request stays high and the committed vector is fixed. The transition *preempt* replaces the commitment only with a source of strictly higher priority. The transition *acknowledge* returns to `ST_IDLE`. On that transition the current priority takes the committed source's priority, and the old level is pushed onto a small last-in-first-out stack. An end-of-interrupt register write pops the stack back into the current priority. A withdrawn source is never dropped from `ST_HELD`, so no spurious vector is ever needed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `cur_pri` is 0, every priority register reads 0, the software flags read 0 and the priority stack is empty.
- R2: `irq_req` rises on the first clock edge after a source becomes effective with a non-zero priority strictly above `cur_pri`. A source at priority 0 or at a priority not above `cur_pri` never raises it.
- R3: Among effective sources the highest priority wins. On equal priority the lowest source number wins.
- R4: While `irq_req` is high, `irq_vec` equals 0x0800 plus 4 times the committed source number (16 bits).
- R5: Once `irq_req` is high it stays high with an unchanged vector until acknowledged, even if the committed source withdraws.
- R6: Before acknowledge, a newly effective source with strictly higher priority than the committed one replaces it. An equal priority does not replace it, even from a lower source number.
- R7: `irq_ack` high while `irq_req` is high loads `cur_pri` at that edge with the committed source's current priority register value, pushes the previous `cur_pri` and drops `irq_req`. `irq_ack` while `irq_req` is low changes nothing.
- R8: A write to address 0x1F3 (end of interrupt) pops the stack into `cur_pri`. The stack holds 8 entries. A push into a full stack is dropped, and a pop from an empty stack leaves `cur_pri` unchanged.
- R9: Sources 0 to 7 are software flags. Writing 1 bits to address 0x1F1 sets the flags, where bit k is source k. Writing 1 bits to address 0x1F2 clears them. Reading 0x1F1 returns the flags.
- R10: Hardware source n (n at least 8) is effective when `hw_flag[n-8]` and `hw_en[n-8]` are 1 and `hw_mask[n-8]` is 0. Enabling or unmasking a source whose flag is already set requests just like a new flag.
- R11: Source 9 is also driven by the OR of the 8 `combo_sub` lines, under the enable and mask of source 9.
- R12: Address n below 222 reads and writes source n's priority in bits 3:0 of the data. Upper write bits are dropped. Address 0x1F0 reads and writes `cur_pri`. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_flag | input | 214 | Hardware request flags, bit k is source k+8 |
| hw_en | input | 214 | Per-source enable for hardware sources |
| hw_mask | input | 214 | Per-source mask for hardware sources |
| combo_sub | input | 8 | Sub-requests ORed into source 9 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Processor acknowledge |
| irq_vec | output | 16 | Vector of the committed source |
| cur_pri | output | 4 | Current priority level |

## Verification
Every result except a read lands on the clock edge after its cause. For a request input this means `irq_req` and `irq_vec` change one edge after the input. For a register write it means the stored value changes at the write edge, and any request that follows from it appears one edge later. `cur_pri` updates at the acknowledge or end-of-interrupt edge itself. The bench drives on the falling edge and samples on the next falling edge, after exactly as many rising edges as the result needs. For the request it also samples just before the deciding edge, to show the output has not yet moved. Register reads are combinational and are sampled a short delay after the address is set.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CUR_PRI = 9'h1F0;
    localparam logic [ADDR_W-1:0] ADR_SW_SET  = 9'h1F1;
    localparam logic [ADDR_W-1:0] ADR_SW_CLR  = 9'h1F2;
    localparam logic [ADDR_W-1:0] ADR_EOI     = 9'h1F3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irq_pri_lifo.sv
module irq_pri_lifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     top_data,
    output logic             empty,
    output logic [CNT_W-1:0] level
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign level    = cnt_q;
    assign top_data = empty ? '0 : mem_q[IDX_W'(cnt_q - CNT_W'(1))];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push) begin
            if (!full) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[s] <= '0;
            end else if (push && !full && (cnt_q == CNT_W'(s))) begin
                mem_q[s] <= push_data;
            end
        end
    end

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 222,
    parameter int unsigned NUM_SW    = 8,
    parameter int unsigned PRI_W     = 4,
    parameter int unsigned STK_DEPTH = 8,
    localparam int unsigned ID_W     = $clog2(NUM_SRC),
    localparam int unsigned CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     ack_fire,
    input  logic [ID_W-1:0]          ack_id,
    output logic [PRI_W-1:0]         ack_pri,
    output logic [NUM_SRC*PRI_W-1:0] prio_flat,
    output logic [NUM_SW-1:0]        sw_flags,
    output logic [PRI_W-1:0]         cpr,
    output logic [CNT_W-1:0]         stk_level
);

    logic [PRI_W-1:0]  prio_q [NUM_SRC];
    logic [PRI_W-1:0]  cpr_q;
    logic [NUM_SW-1:0] sw_q;
    logic              wr_cpr, wr_set, wr_clr, wr_eoi;
    logic              stk_pop, stk_empty;
    logic [PRI_W-1:0]  stk_top;

    assign wr_cpr  = reg_wr && (reg_addr == ADR_CUR_PRI);
    assign wr_set  = reg_wr && (reg_addr == ADR_SW_SET);
    assign wr_clr  = reg_wr && (reg_addr == ADR_SW_CLR);
    assign wr_eoi  = reg_wr && (reg_addr == ADR_EOI);
    assign stk_pop = wr_eoi && !ack_fire;

    irq_pri_lifo #(
        .DEPTH (STK_DEPTH),
        .W     (PRI_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_fire),
        .push_data (cpr_q),
        .pop       (stk_pop),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .level     (stk_level)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[i] <= '0;
            end else if (reg_wr && (reg_addr == ADDR_W'(i))) begin
                prio_q[i] <= reg_wdata[PRI_W-1:0];
            end
        end
        assign prio_flat[i*PRI_W +: PRI_W] = prio_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpr_q <= '0;
        end else if (ack_fire) begin
            cpr_q <= ack_pri;
        end else if (wr_cpr) begin
            cpr_q <= reg_wdata[PRI_W-1:0];
        end else if (stk_pop && !stk_empty) begin
            cpr_q <= stk_top;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (wr_set) begin
            sw_q <= sw_q | reg_wdata[NUM_SW-1:0];
        end else if (wr_clr) begin
            sw_q <= sw_q & ~reg_wdata[NUM_SW-1:0];
        end
    end

    always_comb begin
        ack_pri = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ack_id == ID_W'(i)) begin
                ack_pri = prio_q[i];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_CUR_PRI) begin
            reg_rdata = {{(DATA_W-PRI_W){1'b0}}, cpr_q};
        end else if (reg_addr == ADR_SW_SET) begin
            reg_rdata = {{(DATA_W-NUM_SW){1'b0}}, sw_q};
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (reg_addr == ADDR_W'(i)) begin
                    reg_rdata = {{(DATA_W-PRI_W){1'b0}}, prio_q[i]};
                end
            end
        end
    end

    assign sw_flags = sw_q;
    assign cpr      = cpr_q;

endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick #(
    parameter int unsigned NUM_SRC = 222,
    parameter int unsigned PRI_W   = 4,
    localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*PRI_W-1:0] prio_flat,
    input  logic [PRI_W-1:0]         cpr,
    output logic [ID_W-1:0]          best_id,
    output logic [PRI_W-1:0]         best_pri,
    output logic                     best_hit
);

    // Scan from the top so that a later (lower-numbered) source with an
    // equal priority takes over: ties resolve to the lowest number.
    always_comb begin
        best_id  = '0;
        best_pri = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (prio_flat[i*PRI_W +: PRI_W] != '0) &&
                (prio_flat[i*PRI_W +: PRI_W] >= best_pri)) begin
                best_id  = ID_W'(i);
                best_pri = prio_flat[i*PRI_W +: PRI_W];
            end
        end
        best_hit = (best_pri != '0) && (best_pri > cpr);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 222,
    parameter int unsigned NUM_SW    = 8,
    parameter int unsigned PRI_W     = 4,
    parameter int unsigned COMBO_SRC = 9,
    parameter int unsigned COMBO_W   = 8,
    parameter int unsigned STK_DEPTH = 8,
    parameter int unsigned VEC_W     = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0800,
    localparam int unsigned NUM_HW   = NUM_SRC - NUM_SW,
    localparam int unsigned ID_W     = $clog2(NUM_SRC),
    localparam int unsigned STK_CW   = $clog2(STK_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_HW-1:0]   hw_flag,
    input  logic [NUM_HW-1:0]   hw_en,
    input  logic [NUM_HW-1:0]   hw_mask,
    input  logic [COMBO_W-1:0]  combo_sub,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_req,
    input  logic                irq_ack,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [PRI_W-1:0]    cur_pri
);

    logic [NUM_SRC-1:0]       eff_req;
    logic [NUM_SW-1:0]        sw_flags;
    logic [NUM_SRC*PRI_W-1:0] prio_flat;
    logic [ID_W-1:0]          best_id;
    logic [PRI_W-1:0]         best_pri;
    logic                     best_hit;
    logic [PRI_W-1:0]         ack_pri;
    logic [STK_CW-1:0]        stk_level;
    logic                     ack_fire;

    irq_state_e       state_q, state_d;
    logic [ID_W-1:0]  commit_id_q, commit_id_d;
    logic [PRI_W-1:0] commit_pri_q, commit_pri_d;

    // Effective requests: software flags, then gated hardware lines.
    assign eff_req[NUM_SW-1:0] = sw_flags;

    for (genvar j = 0; j < NUM_HW; j++) begin : g_hw
        logic raw;
        if (j + NUM_SW == COMBO_SRC) begin : g_combo
            assign raw = hw_flag[j] | (|combo_sub);
        end else begin : g_plain
            assign raw = hw_flag[j];
        end
        assign eff_req[j + NUM_SW] = raw & hw_en[j] & ~hw_mask[j];
    end

    irq_prio_regs #(
        .NUM_SRC   (NUM_SRC),
        .NUM_SW    (NUM_SW),
        .PRI_W     (PRI_W),
        .STK_DEPTH (STK_DEPTH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack_fire  (ack_fire),
        .ack_id    (commit_id_q),
        .ack_pri   (ack_pri),
        .prio_flat (prio_flat),
        .sw_flags  (sw_flags),
        .cpr       (cur_pri),
        .stk_level (stk_level)
    );

    irq_best_pick #(
        .NUM_SRC (NUM_SRC),
        .PRI_W   (PRI_W)
    ) u_pick (
        .req       (eff_req),
        .prio_flat (prio_flat),
        .cpr       (cur_pri),
        .best_id   (best_id),
        .best_pri  (best_pri),
        .best_hit  (best_hit)
    );

    // Next-state and commitment logic.
    always_comb begin
        state_d      = state_q;
        commit_id_d  = commit_id_q;
        commit_pri_d = commit_pri_q;
        unique case (state_q)
            ST_IDLE: begin
                if (best_hit) begin
                    state_d      = ST_HELD;
                    commit_id_d  = best_id;
                    commit_pri_d = best_pri;
                end
            end
            ST_HELD: begin
                if (irq_ack) begin
                    state_d = ST_IDLE;
                end else if (best_hit && (best_pri > commit_pri_q)) begin
                    commit_id_d  = best_id;
                    commit_pri_d = best_pri;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            commit_id_q  <= '0;
            commit_pri_q <= '0;
        end else begin
            state_q      <= state_d;
            commit_id_q  <= commit_id_d;
            commit_pri_q <= commit_pri_d;
        end
    end

    // Outputs from the registered state.
    always_comb begin
        irq_req  = (state_q == ST_HELD);
        ack_fire = (state_q == ST_HELD) && irq_ack;
        irq_vec  = VEC_BASE + (VEC_W'(commit_id_q) << 2);
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int unsigned PRI_W     = 4,
    parameter int unsigned STK_DEPTH = 8,
    parameter int unsigned VEC_W     = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0800,
    localparam int unsigned STK_CW   = $clog2(STK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [PRI_W-1:0]  cur_pri,
    input logic              best_hit,
    input logic [PRI_W-1:0]  ack_pri,
    input logic [STK_CW-1:0] stk_level
);

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(best_hit));

    assert_vec_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[1:0] == 2'b00) && (irq_vec >= VEC_BASE));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req);

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req);

    assert_ack_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> cur_pri == $past(ack_pri));

    assert_stack_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= STK_CW'(STK_DEPTH));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .PRI_W     (PRI_W),
    .STK_DEPTH (STK_DEPTH),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_vec   (irq_vec),
    .cur_pri   (cur_pri),
    .best_hit  (best_hit),
    .ack_pri   (ack_pri),
    .stk_level (stk_level)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    localparam int NHW = 214;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NHW-1:0] hw_flag, hw_en, hw_mask;
    logic [7:0]     combo_sub;
    logic           reg_wr;
    logic [8:0]     reg_addr;
    logic [7:0]     reg_wdata, reg_rdata;
    logic           irq_req, irq_ack;
    logic [15:0]    irq_vec;
    logic [3:0]     cur_pri;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_flag(hw_flag), .hw_en(hw_en),
        .hw_mask(hw_mask), .combo_sub(combo_sub), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
        .cur_pri(cur_pri)
    );

    typedef struct packed {
        logic [7:0] ida;
        logic [3:0] pa;
        logic [7:0] idb;
        logic [3:0] pb;
        logic [3:0] cpr;
        logic       exp_irq;
        logic [7:0] exp_id;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'd20,  4'd5,  8'd30,  4'd7,  4'd0,  1'b1, 8'd30},
        '{8'd20,  4'd7,  8'd30,  4'd7,  4'd0,  1'b1, 8'd20},
        '{8'd40,  4'd3,  8'd41,  4'd0,  4'd0,  1'b1, 8'd40},
        '{8'd40,  4'd3,  8'd50,  4'd2,  4'd3,  1'b0, 8'd0},
        '{8'd221, 4'd15, 8'd8,   4'd14, 4'd14, 1'b1, 8'd221},
        '{8'd100, 4'd0,  8'd101, 4'd0,  4'd0,  1'b0, 8'd0}
    };

    function automatic logic [15:0] vec_of(int id);
        return 16'h0800 + 16'(4 * id);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [8:0] a, logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(string req, logic [8:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        hw_flag   = '0;
        hw_en     = '1;
        hw_mask   = '0;
        combo_sub = '0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        irq_ack   = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 cur_pri", 32'(cur_pri), 0);
        rd_check("R1 prio5", 9'd5, 8'h00);
        rd_check("R1 swflags", 9'h1F1, 8'h00);
        rd_check("R1 cpr read", 9'h1F0, 8'h00);

        // Table: R2 priority against level, R3 ordering, R4 vector
        foreach (TBL[k]) begin
            vec_t e = TBL[k];
            do_reset();
            wr(9'(e.ida), 8'(e.pa));
            wr(9'(e.idb), 8'(e.pb));
            wr(9'h1F0, 8'(e.cpr));
            hw_flag[int'(e.ida) - 8] = 1'b1;
            hw_flag[int'(e.idb) - 8] = 1'b1;
            #1;
            check("R2 no early request", 32'(irq_req), 0);
            step(1);
            check("R2 request", 32'(irq_req), 32'(e.exp_irq));
            if (e.exp_irq)
                check("R3 R4 vector", 32'(irq_vec), 32'(vec_of(int'(e.exp_id))));
        end

        // R12 register map
        do_reset();
        wr(9'd37, 8'h3C);
        rd_check("R12 prio low bits", 9'd37, 8'h0C);
        rd_check("R12 unused addr", 9'h1F5, 8'h00);
        wr(9'h1F0, 8'h06);
        rd_check("R12 cpr rw", 9'h1F0, 8'h06);
        check("R12 cur_pri port", 32'(cur_pri), 6);

        // R5 sticky after withdraw
        do_reset();
        wr(9'd50, 8'd6);
        hw_flag[42] = 1'b1;
        step(1);
        check("R5 raised", 32'(irq_req), 1);
        hw_flag[42] = 1'b0;
        step(3);
        check("R5 held", 32'(irq_req), 1);
        check("R5 vector kept", 32'(irq_vec), 32'(vec_of(50)));
        ack();
        check("R5 R7 cpr", 32'(cur_pri), 6);
        check("R5 R7 dropped", 32'(irq_req), 0);

        // R6 preemption only on strictly higher priority
        do_reset();
        wr(9'd60, 8'd3);
        wr(9'd70, 8'd9);
        wr(9'd55, 8'd3);
        hw_flag[52] = 1'b1;
        step(1);
        check("R6 first", 32'(irq_vec), 32'(vec_of(60)));
        hw_flag[47] = 1'b1;
        step(1);
        check("R6 equal keeps", 32'(irq_vec), 32'(vec_of(60)));
        hw_flag[62] = 1'b1;
        step(1);
        check("R6 higher replaces", 32'(irq_vec), 32'(vec_of(70)));
        ack();
        check("R6 R7 cpr", 32'(cur_pri), 9);

        // R7 idle acknowledge ignored
        do_reset();
        wr(9'h1F0, 8'd2);
        ack();
        check("R7 idle ack cpr", 32'(cur_pri), 2);
        wr(9'h1F3, 8'h00);
        check("R7 R8 nothing pushed", 32'(cur_pri), 2);

        // R7 loads current priority register value; R8 restore
        do_reset();
        wr(9'd90, 8'd5);
        hw_flag[82] = 1'b1;
        step(1);
        check("R7 raised", 32'(irq_req), 1);
        wr(9'd90, 8'd11);
        ack();
        check("R7 cpr from prio reg", 32'(cur_pri), 11);
        step(1);
        check("R7 no re-raise at level", 32'(irq_req), 0);
        wr(9'h1F3, 8'h00);
        check("R8 eoi restore", 32'(cur_pri), 0);
        check("R8 not yet raised", 32'(irq_req), 0);
        step(1);
        check("R8 R2 re-raise", 32'(irq_req), 1);

        // R8 overflow and underflow
        do_reset();
        hw_flag[22] = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            wr(9'd30, 8'(k));
            step(1);
            check("R8 raise", 32'(irq_req), 1);
            ack();
            check("R8 push cpr", 32'(cur_pri), 32'(k));
        end
        hw_flag[22] = 1'b0;
        for (int k = 7; k >= 0; k--) begin
            wr(9'h1F3, 8'h00);
            check("R8 pop", 32'(cur_pri), 32'(k));
        end
        wr(9'h1F3, 8'h00);
        check("R8 underflow", 32'(cur_pri), 0);

        // R9 software flags
        do_reset();
        wr(9'd2, 8'd4);
        wr(9'd5, 8'd4);
        wr(9'h1F1, 8'h24);
        check("R9 not yet", 32'(irq_req), 0);
        step(1);
        check("R9 raised", 32'(irq_req), 1);
        check("R9 R3 vector", 32'(irq_vec), 32'(vec_of(2)));
        rd_check("R9 read set", 9'h1F1, 8'h24);
        wr(9'h1F2, 8'h04);
        rd_check("R9 read clr", 9'h1F1, 8'h20);
        ack();
        check("R9 cpr", 32'(cur_pri), 4);

        // R10 enable and mask
        do_reset();
        wr(9'd100, 8'd5);
        hw_en[92]   = 1'b0;
        hw_flag[92] = 1'b1;
        step(2);
        check("R10 disabled", 32'(irq_req), 0);
        hw_en[92]   = 1'b1;
        hw_mask[92] = 1'b1;
        step(2);
        check("R10 masked", 32'(irq_req), 0);
        hw_mask[92] = 1'b0;
        step(1);
        check("R10 unmask raises", 32'(irq_req), 1);
        check("R10 vector", 32'(irq_vec), 32'(vec_of(100)));

        // R11 combined sub-requests on source 9
        do_reset();
        wr(9'd9, 8'd6);
        hw_mask[1] = 1'b1;
        combo_sub  = 8'h80;
        step(2);
        check("R11 masked", 32'(irq_req), 0);
        hw_mask[1] = 1'b0;
        step(1);
        check("R11 raised", 32'(irq_req), 1);
        check("R11 vector", 32'(irq_vec), 32'h0824);

        done = 1;
        summary();
        $finish;
    end

endmodule